// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside a small processor core and turns five interrupt lines into at most one request to the core. The sources, from most to least urgent, are a nonmaskable critical line, an edge-triggered maskable line, two level-triggered maskable lines and a general external line. The block applies a global enable and one mask bit per maskable line. It picks the most urgent source that qualifies. It then presents either a fixed vector address or a flag telling the core to fetch the target instruction from outside.

The core drives a sample strobe in the next-to-last clock of each instruction, and also while halted or while the bus is held. It drives an accept strobe when it takes the offered request. It also drives set-enable and clear-enable commands, a configuration write port that sets masks and clears the edge latch, and a status read strobe. The status port shows the masks, the raw pending state of the three maskable lines, and the enable flag. After a critical interrupt, the status port shows the enable flag as it was before that interrupt.

Top module: `pirq_ctrl`

## Requirements
- R1: On a clock edge where `smp_i` is 1, the block records the most urgent qualifying source, and `req_o` is 1 from the next cycle. Urgency falls in this order: critical, edge line, high level line, low level line, external.
- R2: The vector address on `vec_o` is 24h for the critical line, 3Ch for the edge line, 34h for the high level line and 2Ch for the low level line. `vec_o` is 0 whenever `req_o` is 0.
- R3: When the external line wins, `ext_o` is 1 and `vec_o` is 0. `ext_o` is 0 for every other source and whenever `req_o` is 0.
- R4: The two level lines and the external line qualify only if they are high at the sampling edge, the enable flag is 1 and, for a level line, its mask bit is 0.
- R5: A rising edge on `edge_i` sets a sticky latch even while the edge line is masked. The latch clears when the edge source is accepted, on a configuration write with `cfg_edge_clr_i` set, or on reset. A rising edge in the same cycle as a clear keeps the latch set.
- R6: The critical line ignores the enable flag and the masks. It qualifies only after a rising edge and only while it stays high. After it is accepted, it does not qualify again until it has gone low and then high.
- R7: Accepting any source clears the enable flag. `en_set_i` sets the flag and `en_clr_i` clears it. A critical request is still taken while the flag is 0.
- R8: Accepting the critical source saves the enable flag it replaced. `stat_ie_o` shows that saved value until the first `stat_rd_i` strobe, and shows the current flag after that.
- R9: After reset the enable flag is 0, the edge latch is 0, all three masks are 1 and `req_o` is 0.
- R10: `stat_pend_o` bit 2 is the edge latch, bit 1 is the high level line and bit 0 is the low level line, regardless of the masks.
- R11: A configuration write loads `cfg_mask_i` into the masks only when `cfg_mask_en_i` is 1. Bit 2 masks the edge line, bit 1 the high level line and bit 0 the low level line, and 1 means masked. `stat_mask_o` shows the masks with the same layout.
- R12: An accept while `req_o` is 1 clears `req_o` in the next cycle. A sample with no qualifying source clears `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_i | input | 1 | Nonmaskable critical interrupt line |
| edge_i | input | 1 | Edge-triggered maskable line |
| lvl_hi_i | input | 1 | Level-triggered maskable line, higher urgency |
| lvl_lo_i | input | 1 | Level-triggered maskable line, lower urgency |
| ext_i | input | 1 | General external interrupt line |
| smp_i | input | 1 | Sample strobe from the core |
| ack_i | input | 1 | Accept strobe from the core |
| en_set_i | input | 1 | Set the global enable flag |
| en_clr_i | input | 1 | Clear the global enable flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mask_i | input | 3 | New mask bits (2 edge, 1 high, 0 low) |
| cfg_mask_en_i | input | 1 | Allow the mask bits to load |
| cfg_edge_clr_i | input | 1 | Clear the edge latch on this write |
| stat_rd_i | input | 1 | Status read strobe |
| req_o | output | 1 | Request offered to the core |
| ext_o | output | 1 | Target comes from an external instruction |
| vec_o | output | VEC_W | Vector address of the offered request |
| stat_mask_o | output | 3 | Current masks |
| stat_pend_o | output | 3 | Raw pending state of the maskable lines |
| stat_ie_o | output | 1 | Enable flag, or the saved value after a critical accept |

## Verification
The assertions assume the core never drives `smp_i` and `ack_i` in the same cycle. They also assume `ack_i` never coincides with `en_set_i` or `en_clr_i`, and that both enable commands are never given together. The stimulus drives each strobe in a cycle of its own, so these conditions always hold. The assertions also assume that `edge_i` and `crit_i` are held low through reset. The bench releases reset with every line low.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
    localparam int MASK_W  = 3;
    localparam int NUM_SRC = 5;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CRIT = 3'd1,
        SRC_EDGE = 3'd2,
        SRC_LHI  = 3'd3,
        SRC_LLO  = 3'd4,
        SRC_EXT  = 3'd5
    } src_e;

    function automatic src_e idx_to_src(input int idx);
        case (idx)
            0:       return SRC_CRIT;
            1:       return SRC_EDGE;
            2:       return SRC_LHI;
            3:       return SRC_LLO;
            4:       return SRC_EXT;
            default: return SRC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pirq_crit_qual.sv
`timescale 1ns/1ps
module pirq_crit_qual (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic take_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        logic rise;
        st_d      = st_q;
        rise      = lvl_i & ~st_q.prev;
        st_d.prev = lvl_i;
        // armed by a rise, kept only while the line stays high
        st_d.pend = lvl_i & (st_q.pend | rise) & ~take_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/pirq_edge_latch.sv
`timescale 1ns/1ps
module pirq_edge_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic take_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        logic rise;
        st_d      = st_q;
        rise      = lvl_i & ~st_q.prev;
        st_d.prev = lvl_i;
        // a fresh rise wins over any clear in the same cycle
        st_d.pend = (st_q.pend & ~take_i & ~clr_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/pirq_arbiter.sv
`timescale 1ns/1ps
module pirq_arbiter
    import pirq_pkg::*;
(
    input  logic              crit_pend_i,
    input  logic              edge_pend_i,
    input  logic              lvl_hi_i,
    input  logic              lvl_lo_i,
    input  logic              ext_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              ie_i,
    output logic              any_o,
    output src_e              win_o
);
    logic [NUM_SRC-1:0] cand;

    // index 0 is the most urgent candidate
    assign cand[0] = crit_pend_i;
    assign cand[1] = edge_pend_i & ~mask_i[2] & ie_i;
    assign cand[2] = lvl_hi_i    & ~mask_i[1] & ie_i;
    assign cand[3] = lvl_lo_i    & ~mask_i[0] & ie_i;
    assign cand[4] = ext_i       & ie_i;

    always_comb begin
        any_o = 1'b0;
        win_o = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any_o = 1'b1;
                win_o = idx_to_src(i);
            end
        end
    end
endmodule

// File: rtl/pirq_ctrl.sv
`timescale 1ns/1ps
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int                VEC_W    = 8,
    parameter logic [VEC_W-1:0]  VEC_CRIT = 8'h24,
    parameter logic [VEC_W-1:0]  VEC_EDGE = 8'h3C,
    parameter logic [VEC_W-1:0]  VEC_LHI  = 8'h34,
    parameter logic [VEC_W-1:0]  VEC_LLO  = 8'h2C,
    parameter logic [2:0]        MASK_RST = 3'b111
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             crit_i,
    input  logic             edge_i,
    input  logic             lvl_hi_i,
    input  logic             lvl_lo_i,
    input  logic             ext_i,
    input  logic             smp_i,
    input  logic             ack_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             cfg_wr_i,
    input  logic [2:0]       cfg_mask_i,
    input  logic             cfg_mask_en_i,
    input  logic             cfg_edge_clr_i,
    input  logic             stat_rd_i,
    output logic             req_o,
    output logic             ext_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [2:0]       stat_mask_o,
    output logic [2:0]       stat_pend_o,
    output logic             stat_ie_o
);
    typedef struct packed {
        logic              ie;
        logic              saved_ie;
        logic              show_saved;
        logic [MASK_W-1:0] mask;
        logic              sel_valid;
        src_e              sel_src;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic accept;
    logic take_crit, take_edge;
    logic crit_pend, edge_pend;
    logic any_win;
    src_e win;
    logic ie_q;

    assign accept    = ack_i & st_q.sel_valid;
    assign take_crit = accept & (st_q.sel_src == SRC_CRIT);
    assign take_edge = accept & (st_q.sel_src == SRC_EDGE);

    pirq_crit_qual u_crit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (crit_i),
        .take_i (take_crit),
        .pend_o (crit_pend)
    );

    pirq_edge_latch u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (edge_i),
        .take_i (take_edge),
        .clr_i  (cfg_wr_i & cfg_edge_clr_i),
        .pend_o (edge_pend)
    );

    pirq_arbiter u_arb (
        .crit_pend_i (crit_pend),
        .edge_pend_i (edge_pend),
        .lvl_hi_i    (lvl_hi_i),
        .lvl_lo_i    (lvl_lo_i),
        .ext_i       (ext_i),
        .mask_i      (st_q.mask),
        .ie_i        (st_q.ie),
        .any_o       (any_win),
        .win_o       (win)
    );

    always_comb begin
        st_d = st_q;

        // global enable
        if (accept)        st_d.ie = 1'b0;
        else if (en_set_i) st_d.ie = 1'b1;
        else if (en_clr_i) st_d.ie = 1'b0;

        // enable snapshot taken by a critical accept
        if (take_crit) begin
            st_d.saved_ie   = st_q.ie;
            st_d.show_saved = 1'b1;
        end else if (stat_rd_i) begin
            st_d.show_saved = 1'b0;
        end

        // masks
        if (cfg_wr_i && cfg_mask_en_i) st_d.mask = cfg_mask_i;

        // decision register
        if (smp_i) begin
            st_d.sel_valid = any_win;
            st_d.sel_src   = win;
        end else if (accept) begin
            st_d.sel_valid = 1'b0;
            st_d.sel_src   = SRC_NONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ie         <= 1'b0;
            st_q.saved_ie   <= 1'b0;
            st_q.show_saved <= 1'b0;
            st_q.mask       <= MASK_RST;
            st_q.sel_valid  <= 1'b0;
            st_q.sel_src    <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        vec_o = '0;
        ext_o = 1'b0;
        if (st_q.sel_valid) begin
            case (st_q.sel_src)
                SRC_CRIT: vec_o = VEC_CRIT;
                SRC_EDGE: vec_o = VEC_EDGE;
                SRC_LHI:  vec_o = VEC_LHI;
                SRC_LLO:  vec_o = VEC_LLO;
                SRC_EXT:  ext_o = 1'b1;
                default:  vec_o = '0;
            endcase
        end
    end

    assign ie_q        = st_q.ie;
    assign req_o       = st_q.sel_valid;
    assign stat_mask_o = st_q.mask;
    assign stat_pend_o = {edge_pend, lvl_hi_i, lvl_lo_i};
    assign stat_ie_o   = st_q.show_saved ? st_q.saved_ie : st_q.ie;
endmodule

// File: rtl/pirq_ctrl_chk.sv
`timescale 1ns/1ps
module pirq_ctrl_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             edge_i,
    input logic             smp_i,
    input logic             ack_i,
    input logic             cfg_wr_i,
    input logic             cfg_mask_en_i,
    input logic             req_o,
    input logic             ext_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [2:0]       stat_mask_o,
    input logic [2:0]       stat_pend_o,
    input logic             ie_q
);
    AST_ACK_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && ack_i && !smp_i) |=> !req_o); // R12

    AST_ACCEPT_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && ack_i) |=> !ie_q); // R7

    AST_KIND_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (ext_o ^ (vec_o != '0))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_o |-> (!ext_o && vec_o == '0)); // R2

    AST_EDGE_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(edge_i) |=> stat_pend_o[2]); // R5

    AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cfg_wr_i && cfg_mask_en_i) |=> $stable(stat_mask_o)); // R11
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .edge_i        (edge_i),
    .smp_i         (smp_i),
    .ack_i         (ack_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_mask_en_i (cfg_mask_en_i),
    .req_o         (req_o),
    .ext_o         (ext_o),
    .vec_o         (vec_o),
    .stat_mask_o   (stat_mask_o),
    .stat_pend_o   (stat_pend_o),
    .ie_q          (ie_q)
);

// File: tb/pirq_ctrl_tb.sv
`timescale 1ns/1ps
module pirq_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic crit = 0, edg = 0, lhi = 0, llo = 0, ext = 0;
    logic smp = 0, ack = 0, en_set = 0, en_clr = 0;
    logic cfg_wr = 0, cfg_mask_en = 0, cfg_clr = 0, stat_rd = 0;
    logic [2:0] cfg_mask = 3'b000;
    logic       req, ext_flag, stat_ie;
    logic [7:0] vec;
    logic [2:0] stat_mask, stat_pend;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pirq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .crit_i(crit), .edge_i(edg), .lvl_hi_i(lhi), .lvl_lo_i(llo), .ext_i(ext),
        .smp_i(smp), .ack_i(ack), .en_set_i(en_set), .en_clr_i(en_clr),
        .cfg_wr_i(cfg_wr), .cfg_mask_i(cfg_mask), .cfg_mask_en_i(cfg_mask_en),
        .cfg_edge_clr_i(cfg_clr), .stat_rd_i(stat_rd),
        .req_o(req), .ext_o(ext_flag), .vec_o(vec),
        .stat_mask_o(stat_mask), .stat_pend_o(stat_pend), .stat_ie_o(stat_ie)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model: source codes 0 none, 1 crit, 2 edge, 3 high, 4 low, 5 ext
    int m_ie, m_saved, m_show, m_mask, m_edge, m_eprev, m_crit, m_cprev, m_req, m_src;

    function automatic int vec_of(input int src);
        case (src)
            1: return 'h24;
            2: return 'h3C;
            3: return 'h34;
            4: return 'h2C;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_saved = 0; m_show = 0; m_mask = 7; m_edge = 0;
            m_eprev = 0; m_crit = 0; m_cprev = 0; m_req = 0; m_src = 0;
        end else begin
            int acc, winner, n_crit, n_edge;
            acc = (ack && m_req) ? 1 : 0;
            winner = 0;
            if (m_crit != 0) winner = 1;
            else if (m_ie != 0 && m_edge != 0 && m_mask[2] == 0) winner = 2;
            else if (m_ie != 0 && lhi && m_mask[1] == 0) winner = 3;
            else if (m_ie != 0 && llo && m_mask[0] == 0) winner = 4;
            else if (m_ie != 0 && ext) winner = 5;
            n_crit = (crit && (m_crit != 0 || m_cprev == 0) && !(acc != 0 && m_src == 1)) ? 1 : 0;
            n_edge = ((m_edge != 0 && !(acc != 0 && m_src == 2) && !(cfg_wr && cfg_clr))
                      || (edg && m_eprev == 0)) ? 1 : 0;
            if (acc != 0 && m_src == 1) begin m_saved = m_ie; m_show = 1; end
            else if (stat_rd) m_show = 0;
            if (acc != 0) m_ie = 0;
            else if (en_set) m_ie = 1;
            else if (en_clr) m_ie = 0;
            if (cfg_wr && cfg_mask_en) m_mask = int'(cfg_mask);
            if (smp) begin m_req = (winner != 0) ? 1 : 0; m_src = winner; end
            else if (acc != 0) begin m_req = 0; m_src = 0; end
            m_crit = n_crit; m_edge = n_edge;
            m_cprev = crit ? 1 : 0; m_eprev = edg ? 1 : 0;
        end
        chk("R1 model req", int'(req), m_req);
        chk("R2 model vec", int'(vec), m_req != 0 ? vec_of(m_src) : 0);
        chk("R3 model ext", int'(ext_flag), (m_req != 0 && m_src == 5) ? 1 : 0);
        chk("R8 model stat_ie", int'(stat_ie), m_show != 0 ? m_saved : m_ie);
        chk("R10 model pend", int'(stat_pend), m_edge * 4 + (lhi ? 2 : 0) + (llo ? 1 : 0));
        chk("R11 model mask", int'(stat_mask), m_mask);
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_smp();
        smp = 1; step(); smp = 0;
    endtask

    task automatic pulse_ack();
        ack = 1; step(); ack = 0;
    endtask

    task automatic pulse_en();
        en_set = 1; step(); en_set = 0;
    endtask

    task automatic write_cfg(input logic [2:0] m, input logic men, input logic clr);
        cfg_mask = m; cfg_mask_en = men; cfg_clr = clr; cfg_wr = 1;
        step();
        cfg_wr = 0; cfg_mask_en = 0; cfg_clr = 0;
    endtask

    initial begin
        repeat (3) step();
        // R9 reset state
        chk("R9 reset req", int'(req), 0);
        chk("R9 reset ie", int'(stat_ie), 0);
        chk("R9 reset mask", int'(stat_mask), 7);
        chk("R9 reset pend", int'(stat_pend), 0);
        rst_n = 1;
        step();

        // R11 mask write gated by enable bit
        write_cfg(3'b000, 1'b0, 1'b0);
        chk("R11 mask kept without enable", int'(stat_mask), 7);
        write_cfg(3'b000, 1'b1, 1'b0);
        chk("R11 mask loaded", int'(stat_mask), 0);

        // R1 priority among levels and external
        pulse_en();
        lhi = 1; llo = 1; ext = 1;
        step();
        pulse_smp();
        chk("R1 high level wins", int'(vec), 'h34);
        chk("R1 req raised", int'(req), 1);
        pulse_ack();
        chk("R12 ack drops req", int'(req), 0);
        chk("R7 accept clears enable", int'(stat_ie), 0);

        // R4 level qualifies only while high
        lhi = 0; pulse_en();
        pulse_smp();
        chk("R4 low level after high dropped", int'(vec), 'h2C);
        pulse_ack();
        llo = 0; pulse_en();
        pulse_smp();
        chk("R3 external flag", int'(ext_flag), 1);
        chk("R3 external vec zero", int'(vec), 0);
        pulse_ack();
        ext = 0;

        // R7 disabled blocks maskable sources
        lhi = 1; step();
        pulse_smp();
        chk("R7 no request while disabled", int'(req), 0);
        lhi = 0;

        // R5 edge latched while masked, R10 raw pending
        write_cfg(3'b100, 1'b1, 1'b0);
        edg = 1; step(); edg = 0; step();
        chk("R5 latched while masked", int'(stat_pend), 4);
        pulse_en();
        pulse_smp();
        chk("R12 empty sample no req", int'(req), 0);
        write_cfg(3'b000, 1'b1, 1'b0);
        pulse_smp();
        chk("R2 edge vector", int'(vec), 'h3C);
        pulse_ack();
        chk("R5 accept clears latch", int'(stat_pend), 0);

        // R5 clear by configuration write, masks untouched
        edg = 1; step(); edg = 0; step();
        write_cfg(3'b111, 1'b0, 1'b1);
        chk("R5 config clear", int'(stat_pend), 0);
        chk("R11 mask unchanged on clear", int'(stat_mask), 0);

        // R6 critical ignores enable, needs re-arm
        write_cfg(3'b111, 1'b1, 1'b0);
        crit = 1; step();
        pulse_smp();
        chk("R6 critical while disabled", int'(vec), 'h24);
        pulse_ack();
        pulse_smp();
        chk("R6 held high not retaken", int'(req), 0);
        crit = 0; step(); crit = 1; step();
        pulse_smp();
        chk("R6 retaken after re-arm", int'(vec), 'h24);
        pulse_ack();

        // R8 saved enable shown once
        crit = 0; step();
        pulse_en();
        crit = 1; step();
        lhi = 1; write_cfg(3'b000, 1'b1, 1'b0);
        pulse_smp();
        chk("R1 critical beats level", int'(vec), 'h24);
        pulse_ack();
        chk("R8 saved enable shown", int'(stat_ie), 1);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R8 current enable after read", int'(stat_ie), 0);
        lhi = 0;

        // R6 critical dropped before sample is lost
        crit = 0; step(); crit = 1; step(); crit = 0; step();
        pulse_smp();
        chk("R6 dropped critical cancelled", int'(req), 0);

        // R7 clear-enable command
        pulse_en();
        en_clr = 1; step(); en_clr = 0;
        chk("R7 clear command", int'(stat_ie), 0);

        // R9 reset clears latch and enable
        pulse_en();
        edg = 1; step(); edg = 0; step();
        rst_n = 0; step();
        chk("R9 reset clears latch", int'(stat_pend), 0);
        chk("R9 reset clears enable", int'(stat_ie), 0);
        chk("R9 reset restores masks", int'(stat_mask), 7);
        rst_n = 1; step(); step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule